// File: doc/BRIEF.md
# Per-Word Coherence State Controller for a Self-Invalidating Private Cache

This block holds the coherence state of every word in a small private cache. The coherence scheme never sends invalidations from a writer to readers. Instead, a reader drops its own possibly stale copies when the core reaches a synchronization point. Each word is in one of three stable states: Invalid, Valid or Registered. There are no transient states. The core presents loads, stores and synchronization loads one at a time. The block answers at once when the access hits. On a miss it sends one request toward the shared-cache registry and finishes the access when that request is acknowledged.

Ownership can be taken away by another core. The registry then forwards a registration for a word to this block. If the word is held Registered, the block drops it to Invalid and pulses a hand-over strobe so the current value can be returned. A self-invalidate pulse, given at a synchronization point, clears every Valid word that the core did not use during the phase that just ended. Registered words are kept. Each word carries a touched flag that records use during the current phase.

Top module: `wordstate_ctl`

## Requirements
- R1: After reset every word is Invalid and every touched flag is clear, so the first access to any word is a miss; `req_ready` is 1 while no miss is outstanding and no self-invalidate is applied.
- R2: A data load (`req_op`=0) to an Invalid word misses. It sends a read request (`out_kind`=0) and the word becomes Valid when the miss completes. A data load to a Valid or Registered word hits, and `rsp_valid`=1 with `rsp_hit`=1 appears in the cycle after acceptance.
- R3: A store (`req_op`=1, or 3 for a synchronization store) hits only when the word is Registered. Otherwise it sends a registration request (`out_kind`=1) and the word becomes Registered in the cycle after acceptance, without waiting for the acknowledgement.
- R4: A synchronization load (`req_op`=2) hits only when the word is Registered. Otherwise it sends a registration request (`out_kind`=1), and the word becomes Registered when the miss completes, so later synchronization loads hit.
- R5: A self-invalidate pulse turns every Valid word whose touched flag is clear into Invalid. It keeps Valid words whose flag is set, and it keeps every Registered word.
- R6: A forwarded registration (`fwd_valid`) for a Registered word makes the word Invalid and pulses `xfer_valid` with `xfer_idx` equal to the word in the next cycle. For a word that is not Registered it has no effect and gives no pulse.
- R7: At most one miss is outstanding. `out_valid` pulses in the cycle after a miss is accepted, and `req_ready` stays 0 until `ack_valid` arrives. The cycle after the acknowledgement gives `rsp_valid`=1 with `rsp_hit`=0. An `ack_valid` while no miss is outstanding is ignored.
- R8: Any accepted access sets the word's touched flag, and so does the fill at the end of a miss. A self-invalidate clears all touched flags, so a word that is Valid and left unused for one whole phase is dropped at the second self-invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request valid |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_op | input | 2 | 0 data load, 1 store, 2 synchronization load, 3 synchronization store |
| req_idx | input | IDX_W | Word index of the access |
| rsp_valid | output | 1 | Access completed |
| rsp_hit | output | 1 | 1 when the completed access hit, 0 when it ended a miss |
| out_valid | output | 1 | Request to the registry valid (one-cycle pulse) |
| out_kind | output | 1 | 0 read request, 1 registration request |
| out_idx | output | IDX_W | Word index of the outgoing request |
| ack_valid | input | 1 | Registry acknowledgement of the outstanding miss |
| fwd_valid | input | 1 | Another core registers a word |
| fwd_idx | input | IDX_W | Word index of the forwarded registration |
| xfer_valid | output | 1 | Hand-over of a registered word to another core |
| xfer_idx | output | IDX_W | Word index being handed over |
| selfinv | input | 1 | Self-invalidate pulse at a synchronization point |

## Verification
Directed sequences try each access kind in each of the three states. A load sequence tells read requests apart from registration requests, and a pair of self-invalidates separates words kept because they were touched from words that were left unused. A forwarded registration that arrives while a store miss is still waiting for its acknowledgement checks that ownership is given up before the store completes. An acknowledgement with no miss outstanding checks that it is ignored. A seeded random mix of accesses, forwards, self-invalidates and acknowledgement delays over a few words checks every hit or miss decision, request kind and hand-over strobe against a state model kept in the bench.

// File: rtl/wordstate_pkg.sv
package wordstate_pkg;
   typedef enum logic [1:0] {
      W_INV = 2'b00,
      W_VAL = 2'b01,
      W_REG = 2'b10
   } wstate_t;

   typedef enum logic [1:0] {
      OP_LOAD   = 2'b00,
      OP_STORE  = 2'b01,
      OP_SYNCLD = 2'b10,
      OP_SYNCST = 2'b11
   } acc_op_t;

   function automatic logic op_is_store(input acc_op_t op);
      return (op == OP_STORE) || (op == OP_SYNCST);
   endfunction

   function automatic logic access_hits(input acc_op_t op, input wstate_t s);
      if (op == OP_LOAD) return s != W_INV;
      return s == W_REG;
   endfunction
endpackage

// File: rtl/word_cell.sv
module word_cell
   import wordstate_pkg::*;
#(
   parameter bit KEEP_TOUCHED = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    acc_en,
   input  logic    acc_store,
   input  logic    fill_en,
   input  wstate_t fill_state,
   input  logic    fwd_en,
   input  logic    selfinv,
   output wstate_t state,
   output logic    touched,
   output logic    give_up
);
   wstate_t st_q, st_d;
   logic    tch_q, tch_d;
   logic    drop_valid;

   generate
      if (KEEP_TOUCHED) begin : g_keep
         assign drop_valid = !tch_q;
      end else begin : g_all
         assign drop_valid = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      tch_d   = tch_q;
      give_up = 1'b0;
      if (selfinv) begin
         if (st_d == W_VAL && drop_valid) st_d = W_INV;
         tch_d = 1'b0;
      end
      if (acc_en) begin
         tch_d = 1'b1;
         if (acc_store) st_d = W_REG;
      end
      if (fill_en) begin
         st_d  = fill_state;
         tch_d = 1'b1;
      end
      if (fwd_en && st_d == W_REG) begin
         give_up = 1'b1;
         st_d    = W_INV;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= W_INV;
         tch_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         tch_q <= tch_d;
      end
   end

   assign state   = st_q;
   assign touched = tch_q;

   assert_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st_q inside {W_INV, W_VAL, W_REG});
   assert_store_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_store && !fwd_en) |=> (st_q == W_REG));
   assert_keep_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (selfinv && st_q == W_REG && !fwd_en && !fill_en) |=> (st_q == W_REG));
   assert_fwd_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en && st_q == W_REG && !acc_en && !fill_en) |=> (st_q == W_INV));
   assert_touch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !selfinv) |=> tch_q);
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
   import wordstate_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  acc_op_t          start_op,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             ack,
   output logic             pend,
   output logic             done,
   output logic             fill_en,
   output wstate_t          fill_state,
   output logic [IDX_W-1:0] fill_idx,
   output logic             out_valid,
   output logic             out_kind,
   output logic [IDX_W-1:0] out_idx
);
   acc_op_t pend_op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_op   <= OP_LOAD;
         fill_idx  <= '0;
         out_valid <= 1'b0;
         out_kind  <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= start;
         if (start) begin
            pend     <= 1'b1;
            pend_op  <= start_op;
            fill_idx <= start_idx;
            out_kind <= (start_op != OP_LOAD);
            out_idx  <= start_idx;
         end else if (ack && pend) begin
            pend <= 1'b0;
         end
      end
   end

   assign done       = ack && pend;
   assign fill_en    = done && !op_is_store(pend_op);
   assign fill_state = (pend_op == OP_LOAD) ? W_VAL : W_REG;

   assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !start);
endmodule

// File: rtl/wordstate_ctl.sv
module wordstate_ctl
   import wordstate_pkg::*;
#(
   parameter int NWORDS       = 8,
   parameter bit KEEP_TOUCHED = 1'b1,
   localparam int IDX_W       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_op,
   input  logic [IDX_W-1:0] req_idx,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             out_valid,
   output logic             out_kind,
   output logic [IDX_W-1:0] out_idx,
   input  logic             ack_valid,
   input  logic             fwd_valid,
   input  logic [IDX_W-1:0] fwd_idx,
   output logic             xfer_valid,
   output logic [IDX_W-1:0] xfer_idx,
   input  logic             selfinv
);
   initial begin
      if (NWORDS < 2 || (NWORDS & (NWORDS - 1)) != 0)
         $error("NWORDS must be a power of two, at least 2");
   end

   wstate_t          st_vec [NWORDS];
   logic [NWORDS-1:0] tch_vec, give_vec;
   logic             pend, done, fill_en;
   wstate_t          fill_state;
   logic [IDX_W-1:0] fill_idx;
   acc_op_t          op;
   wstate_t          cur;
   logic             accept, hit;

   assign op        = acc_op_t'(req_op);
   assign req_ready = !pend && !selfinv;
   assign accept    = req_valid && req_ready;
   assign cur       = st_vec[req_idx];
   assign hit       = access_hits(op, cur);

   miss_tracker #(.IDX_W(IDX_W)) u_miss (
      .clk(clk), .rst_n(rst_n),
      .start(accept && !hit), .start_op(op), .start_idx(req_idx),
      .ack(ack_valid), .pend(pend), .done(done),
      .fill_en(fill_en), .fill_state(fill_state), .fill_idx(fill_idx),
      .out_valid(out_valid), .out_kind(out_kind), .out_idx(out_idx)
   );

   generate
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         word_cell #(.KEEP_TOUCHED(KEEP_TOUCHED)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .acc_en(accept && req_idx == IDX_W'(w)),
            .acc_store(op_is_store(op)),
            .fill_en(fill_en && fill_idx == IDX_W'(w)),
            .fill_state(fill_state),
            .fwd_en(fwd_valid && fwd_idx == IDX_W'(w)),
            .selfinv(selfinv),
            .state(st_vec[w]),
            .touched(tch_vec[w]),
            .give_up(give_vec[w])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         xfer_valid <= 1'b0;
         xfer_idx   <= '0;
      end else begin
         rsp_valid  <= (accept && hit) || done;
         rsp_hit    <= accept && hit;
         xfer_valid <= |give_vec;
         xfer_idx   <= fwd_idx;
      end
   end

   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready);
   assert_ack_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !req_ready && !selfinv) |=> (rsp_valid && !rsp_hit));
   assert_sync_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_SYNCLD && cur == W_REG) |=> (rsp_valid && rsp_hit));
   assert_load_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_LOAD && cur != W_INV) |=> (rsp_valid && rsp_hit && !out_valid));
   assert_no_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_valid |=> !xfer_valid);
endmodule

// File: tb/sim_wordstate_ctl.sv
module sim_wordstate_ctl;
   localparam int NW = 8;
   localparam int IW = 3;
   localparam logic [1:0] S_I = 2'd0, S_V = 2'd1, S_R = 2'd2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, ack_valid = 1'b0, fwd_valid = 1'b0, selfinv = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [IW-1:0] req_idx = '0, fwd_idx = '0;
   logic req_ready, rsp_valid, rsp_hit, out_valid, out_kind, xfer_valid;
   logic [IW-1:0] out_idx, xfer_idx;

   int total = 0, bad = 0;
   logic [1:0] m_st [NW];
   logic       m_tch [NW];

   always #5 clk = ~clk;

   wordstate_ctl #(.NWORDS(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_idx(req_idx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .out_valid(out_valid), .out_kind(out_kind), .out_idx(out_idx),
      .ack_valid(ack_valid), .fwd_valid(fwd_valid), .fwd_idx(fwd_idx),
      .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .selfinv(selfinv)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_hit(input logic [1:0] op, input logic [1:0] s);
      if (op == 2'd0) return s != S_I;
      return s == S_R;
   endfunction

   task automatic do_req(input logic [1:0] op, input int idx, input int dly, input string req);
      bit e;
      @(negedge clk);
      chk(req_ready, "R7 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_op = op; req_idx = IW'(idx);
      e = exp_hit(op, m_st[idx]);
      @(negedge clk);
      req_valid = 1'b0;
      m_tch[idx] = 1'b1;
      if (op[0]) m_st[idx] = S_R;
      if (e) begin
         chk(rsp_valid && rsp_hit && !out_valid, {req, " hit"}, {rsp_valid, rsp_hit}, 3);
      end else begin
         chk(!rsp_valid && out_valid && out_kind == (op != 2'd0) && out_idx == IW'(idx),
             {req, " miss request"}, {out_valid, out_kind}, {1'b1, op != 2'd0});
         for (int k = 0; k < dly; k++) begin
            chk(!req_ready, "R7 stall while pending", req_ready, 0);
            @(negedge clk);
         end
         ack_valid = 1'b1;
         @(negedge clk);
         ack_valid = 1'b0;
         chk(rsp_valid && !rsp_hit, "R7 miss completion", {rsp_valid, rsp_hit}, 2);
         if (op == 2'd0) begin m_st[idx] = S_V; m_tch[idx] = 1'b1; end
         if (op == 2'd2) begin m_st[idx] = S_R; m_tch[idx] = 1'b1; end
      end
   endtask

   task automatic do_fwd(input int idx);
      bit e;
      @(negedge clk);
      fwd_valid = 1'b1; fwd_idx = IW'(idx);
      e = (m_st[idx] == S_R);
      @(negedge clk);
      fwd_valid = 1'b0;
      chk(xfer_valid == e && (!e || xfer_idx == IW'(idx)), "R6 hand-over", xfer_valid, e);
      if (e) m_st[idx] = S_I;
   endtask

   task automatic do_sinv();
      @(negedge clk);
      selfinv = 1'b1;
      for (int w = 0; w < NW; w++) begin
         if (m_st[w] == S_V && !m_tch[w]) m_st[w] = S_I;
         m_tch[w] = 1'b0;
      end
      @(negedge clk);
      selfinv = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int w = 0; w < NW; w++) begin m_st[w] = S_I; m_tch[w] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !out_valid && !xfer_valid, "R1 reset outputs", req_ready, 1);

      // R1/R2: first load misses with a read request, then hits
      do_req(2'd0, 0, 2, "R1 first load");
      do_req(2'd0, 0, 0, "R2 load in Valid");
      // R4: sync load in Valid misses, registers, then hits
      do_req(2'd2, 0, 1, "R4 sync load in Valid");
      do_req(2'd2, 0, 0, "R4 sync load in Registered");
      do_req(2'd0, 0, 0, "R2 load in Registered");
      // R3: store in Invalid, then store hits
      do_req(2'd1, 1, 3, "R3 store in Invalid");
      do_req(2'd3, 1, 0, "R3 sync store in Registered");
      // R6: forward to a non-registered word does nothing
      do_fwd(2);
      do_req(2'd0, 2, 0, "R6 untouched word still Invalid");
      do_fwd(1);
      do_req(2'd2, 1, 0, "R6 word dropped after forward");

      // R5/R8: touched Valid kept once, dropped after an idle phase; Registered kept
      do_req(2'd0, 3, 1, "R8 load fills");
      do_sinv();
      do_req(2'd2, 0, 0, "R5 Registered kept");
      do_sinv();
      do_sinv();
      do_req(2'd0, 0, 0, "R5 Registered survives phases");
      do_req(2'd0, 3, 0, "R8 idle Valid dropped");
      do_req(2'd0, 4, 0, "R2 load fill");
      do_sinv();
      do_req(2'd0, 4, 0, "R8 touched word kept");

      // R7: stray acknowledgement ignored
      @(negedge clk);
      ack_valid = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0;
      chk(!rsp_valid && req_ready, "R7 stray ack ignored", rsp_valid, 0);

      // R3/R6: forward while a store miss waits for its acknowledgement
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd1; req_idx = 3'd5;
      @(negedge clk);
      req_valid = 1'b0;
      chk(out_valid && out_kind, "R3 store registration", out_kind, 1);
      fwd_valid = 1'b1; fwd_idx = 3'd5;
      @(negedge clk);
      fwd_valid = 1'b0;
      chk(xfer_valid && xfer_idx == 3'd5, "R3 registered before ack", xfer_valid, 1);
      ack_valid = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0;
      chk(rsp_valid && !rsp_hit, "R7 store completes", rsp_valid, 1);
      m_st[5] = S_I; m_tch[5] = 1'b1;
      do_req(2'd2, 5, 0, "R6 ownership given up");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int r;
         r = $urandom % 10;
         if (r < 7) do_req(2'($urandom % 4), $urandom % 4, $urandom % 4, "R2 R3 R4 random access");
         else if (r < 9) do_fwd($urandom % 4);
         else do_sinv();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule